// File: doc/BRIEF.md
# Triangle Spread-Spectrum Divider Modulator

This block produces the feedback-divider value that a fractional-N synthesizer loop consumes. It spreads the synthesized frequency by slowly moving that divider around a programmed base value. The base divider is a fixed-point number with a 12-bit integer part and a 24-bit fractional part. The modulation profile is a 128-point triangle. A programmable rate divider sets how often the triangle advances. A 5-bit depth field scales the peak deviation in steps of 0.1% of the base divider.

Two spread shapes are offered. Center spread swings the divider symmetrically above and below the base, by up to half the programmed depth each way. Down spread only ever lowers the divider, reaching the full depth below the base at the peak of the triangle. A bypass input and a reset input each hold the modulator idle. While either is set, the base divider passes through unchanged. When both are released, the wave restarts from its zero-offset point. The output is registered, so a change on any input shows at the outputs one clock later.

Top module: `ss_spread_mod`

## Requirements
- R1: While rst_ni is low, the divider outputs are integer 0x010 with fraction 0, and the wave index is 0.
- R2: When bypass_i is 1, the divider outputs on the next clock equal the base divider inputs, and the wave index is 0.
- R3: When mod_reset_i is 1, the modulator is held exactly as in R2. This takes priority over a pending index advance.
- R4: When not held, the wave index (0..127) advances by one on each rate tick, wraps from 127 to 0, and otherwise stays put.
- R5: When not held, a rate tick occurs once every N clocks, where N is rate_div_i. A rate_div_i of 0 behaves as 1.
- R6: Down spread (down_spread_i = 1): the output is B - floor(B*depth*t/64000). Here B is the 36-bit base, t = i for i < 64 and t = 128 - i otherwise, and i is the index before the clock edge. The output never exceeds B.
- R7: Center spread (down_spread_i = 0): let c = t((i+32) mod 128) - 32, which lies in -32..32. The output is B + floor(B*depth*c/64000) for c >= 0, and B - floor(B*depth*|c|/64000) for c < 0.
- R8: On the first clock after bypass and reset are both released, the output equals the base and the index starts from 0.
- R9: In center spread, a result that exceeds the 36-bit range saturates to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| base_int_i | input | 12 | Base divider, integer part |
| base_frac_i | input | 24 | Base divider, fractional part |
| bypass_i | input | 1 | Pass the base divider through unmodulated |
| mod_reset_i | input | 1 | Hold the modulator in reset |
| down_spread_i | input | 1 | 1 = down spread, 0 = center spread |
| rate_div_i | input | 6 | Clocks per wave step (0 treated as 1) |
| depth_i | input | 5 | Peak deviation in 0.1% units |
| div_int_o | output | 12 | Modulated divider, integer part |
| div_frac_o | output | 24 | Modulated divider, fractional part |
| wave_idx_o | output | 7 | Current triangle index |

## Verification
The modulator reset and a rate tick can land on the same clock. The hold must win, so the index goes to 0 instead of advancing. The bench provokes this by running at one step per clock until the index reaches 126, then raising mod_reset_i on the edge that would otherwise take the index to 127. An index of 0, rather than 127, after that edge shows the correct priority. The per-clock reference model then checks the restart from zero offset that follows. Other sequences cover a rate change in the middle of a count and a mode switch while the wave is running.

// File: rtl/ss_mod_pkg.sv
package ss_mod_pkg;
  typedef enum logic {
    SPREAD_CENTER = 1'b0,
    SPREAD_DOWN   = 1'b1
  } spread_e;
endpackage

// File: rtl/ss_rate_tick.sv
module ss_rate_tick #(
  parameter int RATE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;
  logic [RATE_W-1:0] eff_rate;

  assign eff_rate = (rate_i == '0) ? RATE_W'(1) : rate_i;
  // compare with >= so a rate lowered mid-count fires at once
  assign tick_o   = !hold_i && (cnt_q >= eff_rate - RATE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (hold_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + RATE_W'(1);
  end

  // R5: a rate of 0 or 1 ticks on every unheld clock
  a_r5_unit_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && rate_i <= RATE_W'(1)) |-> tick_o);
endmodule

// File: rtl/ss_wave_phase.sv
module ss_wave_phase #(
  parameter int IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             tick_i,
  output logic [IDX_W-1:0] idx_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_o <= '0;
    else if (hold_i)  idx_o <= '0;
    else if (tick_i)  idx_o <= idx_o + IDX_W'(1);
  end

  // R3: a hold clears the index, even when a tick is pending
  a_r3_hold_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> idx_o == '0);
  // R4: one step per tick, wrapping at the top
  a_r4_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && tick_i) |=> idx_o == $past(idx_o) + IDX_W'(1));
  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !tick_i) |=> $stable(idx_o));
endmodule

// File: rtl/ss_offset_mix.sv
module ss_offset_mix
  import ss_mod_pkg::*;
#(
  parameter int INT_W     = 12,
  parameter int FRAC_W    = 24,
  parameter int DEPTH_W   = 5,
  parameter int IDX_W     = 7,
  parameter int DEPTH_DEN = 1000,
  parameter int RST_INT   = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hold_i,
  input  spread_e                 mode_i,
  input  logic [INT_W+FRAC_W-1:0] base_i,
  input  logic [DEPTH_W-1:0]      depth_i,
  input  logic [IDX_W-1:0]        idx_i,
  output logic [INT_W+FRAC_W-1:0] div_o
);
  localparam int BASE_W    = INT_W + FRAC_W;
  localparam int PROD_W    = BASE_W + DEPTH_W + IDX_W;
  localparam int FULL      = 2 ** IDX_W;
  localparam int HALF      = FULL / 2;
  localparam int QTR       = HALF / 2;
  localparam int DIV_CONST = DEPTH_DEN * HALF;
  localparam logic [BASE_W-1:0] RST_VAL = BASE_W'(RST_INT) << FRAC_W;

  // returns {negative, magnitude} of the wave sample at a phase
  function automatic logic [IDX_W:0] wave_point(input logic [IDX_W-1:0] ph,
                                                input logic dn);
    int p;
    int m;
    logic ng;
    p = int'(ph);
    if (dn) begin
      ng = 1'b1;
      m  = (p < HALF) ? p : FULL - p;
    end else if (p < QTR) begin
      ng = 1'b0; m = p;
    end else if (p <= HALF) begin
      ng = 1'b0; m = HALF - p;
    end else if (p < HALF + QTR) begin
      ng = 1'b1; m = p - HALF;
    end else begin
      ng = 1'b1; m = FULL - p;
    end
    return {ng, m[IDX_W-1:0]};
  endfunction

  function automatic logic [BASE_W-1:0] scaled_offset(input logic [BASE_W-1:0]  b,
                                                      input logic [DEPTH_W-1:0] d,
                                                      input logic [IDX_W-1:0]   m);
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quo;
    prod = PROD_W'(b) * PROD_W'(d) * PROD_W'(m);
    quo  = prod / PROD_W'(DIV_CONST);
    return quo[BASE_W-1:0];
  endfunction

  logic [IDX_W:0]      pt;
  logic [BASE_W-1:0]   off;
  logic [BASE_W:0]     sum;
  logic [BASE_W-1:0]   nxt;

  always_comb begin
    pt  = wave_point(idx_i, mode_i == SPREAD_DOWN);
    off = scaled_offset(base_i, depth_i, pt[IDX_W-1:0]);
    sum = {1'b0, base_i} + {1'b0, off};
    if (pt[IDX_W])           nxt = base_i - off;
    else if (sum[BASE_W])    nxt = '1;
    else                     nxt = sum[BASE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      div_o <= RST_VAL;
    else if (hold_i)  div_o <= base_i;
    else              div_o <= nxt;
  end

  // R2: a held modulator passes the base through
  a_r2_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> div_o == $past(base_i));
  // R6: down spread never exceeds the base
  a_r6_never_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && mode_i == SPREAD_DOWN) |=> div_o <= $past(base_i));
  // R7: in center spread, a sample with a non-negative offset never falls below the base
  a_r7_upper_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && mode_i == SPREAD_CENTER && !pt[IDX_W]) |=> div_o >= $past(base_i));
endmodule

// File: rtl/ss_spread_mod.sv
module ss_spread_mod
  import ss_mod_pkg::*;
#(
  parameter int INT_W     = 12,
  parameter int FRAC_W    = 24,
  parameter int DEPTH_W   = 5,
  parameter int RATE_W    = 6,
  parameter int IDX_W     = 7,
  parameter int DEPTH_DEN = 1000,
  parameter int RST_INT   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INT_W-1:0]   base_int_i,
  input  logic [FRAC_W-1:0]  base_frac_i,
  input  logic               bypass_i,
  input  logic               mod_reset_i,
  input  logic               down_spread_i,
  input  logic [RATE_W-1:0]  rate_div_i,
  input  logic [DEPTH_W-1:0] depth_i,
  output logic [INT_W-1:0]   div_int_o,
  output logic [FRAC_W-1:0]  div_frac_o,
  output logic [IDX_W-1:0]   wave_idx_o
);
  localparam int BASE_W = INT_W + FRAC_W;

  logic              hold;
  logic              tick;
  logic [BASE_W-1:0] base;
  logic [BASE_W-1:0] div_q;
  spread_e           mode;

  assign hold = bypass_i | mod_reset_i;
  assign base = {base_int_i, base_frac_i};
  assign mode = spread_e'(down_spread_i);

  ss_rate_tick #(.RATE_W(RATE_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold),
    .rate_i(rate_div_i), .tick_o(tick)
  );

  ss_wave_phase #(.IDX_W(IDX_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold),
    .tick_i(tick), .idx_o(wave_idx_o)
  );

  ss_offset_mix #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W),
    .DEPTH_DEN(DEPTH_DEN), .RST_INT(RST_INT)
  ) u_mix (
    .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold), .mode_i(mode),
    .base_i(base), .depth_i(depth_i), .idx_i(wave_idx_o), .div_o(div_q)
  );

  assign div_int_o  = div_q[BASE_W-1:FRAC_W];
  assign div_frac_o = div_q[FRAC_W-1:0];

  // R8: the first unheld clock after a hold yields the base value
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hold) && !hold) |=> div_q == $past(base));
endmodule

// File: tb/ss_spread_mod_tb_top.sv
module ss_spread_mod_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] b_int = 12'h010;
  logic [23:0] b_frac = 24'h0;
  logic        byp = 1'b1, mrst = 1'b0, dn = 1'b0;
  logic [5:0]  rate = 6'd1;
  logic [4:0]  depth = 5'd1;
  logic [11:0] d_int;
  logic [23:0] d_frac;
  logic [6:0]  d_idx;

  always #4 clk = ~clk;

  ss_spread_mod dut_i (
    .clk_i(clk), .rst_ni(rst_n), .base_int_i(b_int), .base_frac_i(b_frac),
    .bypass_i(byp), .mod_reset_i(mrst), .down_spread_i(dn),
    .rate_div_i(rate), .depth_i(depth),
    .div_int_o(d_int), .div_frac_o(d_frac), .wave_idx_o(d_idx)
  );

  localparam longint unsigned MAXB = (64'd1 << 36) - 64'd1;

  int total = 0, bad = 0;
  string tag = "R1";
  bit chk_en = 1'b0;
  longint unsigned m_out = 64'h10 << 24, m_base = 0;
  int m_cnt = 0, m_idx = 0, prev_idx = 0;

  function automatic int tri_at(int k);
    return (k <= 64) ? k : 128 - k;
  endfunction

  function automatic longint unsigned ref_out(longint unsigned b, int d, int i, bit down);
    int w;
    longint unsigned mag, off;
    if (down) w = -tri_at(i);
    else      w = tri_at((i + 32) % 128) - 32;
    mag = longint'(w < 0 ? -w : w);
    off = (b * longint'(d) * mag) / 64'd64000;
    if (w < 0) return b - off;
    if (b + off > MAXB) return MAXB;
    return b + off;
  endfunction

  // reference model, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    longint unsigned cur_b;
    int eff;
    cur_b = {28'd0, b_int, b_frac};
    if (!rst_n) begin
      m_cnt = 0; m_idx = 0; m_out = 64'h10 << 24;
    end else if (byp || mrst) begin
      m_cnt = 0; m_idx = 0; m_out = cur_b;
    end else begin
      m_out = ref_out(cur_b, int'(depth), m_idx, dn);
      eff = (rate == 0) ? 1 : int'(rate);
      if (m_cnt + 1 >= eff) begin
        m_cnt = 0; m_idx = (m_idx + 1) % 128;
      end else m_cnt++;
    end
    m_base = cur_b;
  end

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    longint unsigned got;
    if (chk_en) begin
      got = {28'd0, d_int, d_frac};
      check(got == m_out, tag, got, m_out);
      check(int'(d_idx) == m_idx, {tag, " index"}, d_idx, m_idx);
      if (tag == "R6") check(got <= m_base, "R6 bound", got, m_base);
      if (prev_idx == 127 && int'(d_idx) != 127 && !byp && !mrst)
        check(d_idx == 7'd0, "R4 wrap", d_idx, 0);
      prev_idx = int'(d_idx);
    end
  end

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_en = 1'b1;
    @(negedge clk);
    check(d_int == 12'h010 && d_frac == 24'h0 && d_idx == 7'd0, "R1",
          {d_int, d_frac}, 64'h10 << 24);
    rst_n = 1'b1;
    // R2: bypass passes the base through
    tag = "R2"; b_int = 12'h064; b_frac = 24'h123456;
    repeat (10) @(negedge clk);
    check({d_int, d_frac} == {b_int, b_frac}, "R2", {d_int, d_frac}, {b_int, b_frac});
    // R8 then R6: leave bypass into down spread
    byp = 1'b0; dn = 1'b1; depth = 5'd31; rate = 6'd1;
    tag = "R8";
    @(negedge clk);
    check({d_int, d_frac} == {b_int, b_frac}, "R8", {d_int, d_frac}, {b_int, b_frac});
    tag = "R6";
    repeat (300) @(negedge clk);
    // R7 center spread with a slower rate
    tag = "R7"; dn = 1'b0; depth = 5'd17; rate = 6'd3;
    repeat (500) @(negedge clk);
    // R5 rate extremes
    tag = "R5"; rate = 6'd0;
    repeat (40) @(negedge clk);
    rate = 6'd63; depth = 5'd5;
    repeat (300) @(negedge clk);
    // R3: reset bit raised on the edge that would step 126 -> 127
    tag = "R3"; rate = 6'd1; depth = 5'd20;
    for (int k = 0; k < 200; k++) begin
      if (m_idx == 126) break;
      @(negedge clk);
    end
    mrst = 1'b1;
    @(negedge clk);
    check(d_idx == 7'd0, "R3 priority", d_idx, 0);
    repeat (5) @(negedge clk);
    mrst = 1'b0;
    repeat (200) @(negedge clk);
    // R9 saturation at the top of the range
    tag = "R9"; b_int = 12'hFFF; b_frac = 24'hFFFFFF; depth = 5'd31;
    repeat (200) @(negedge clk);
    check({d_int, d_frac} <= 36'hFFFFFFFFF, "R9", {d_int, d_frac}, MAXB);
    chk_en = 1'b0;
    summary();
  end
endmodule